// File: doc/BRIEF.md
# Dual-Stream Instruction Bundle Sequencer

This block fetches wide instructions whose two halves are stored in two separate code streams that grow apart from one shared entry address. The upward half is laid out at rising addresses starting at the entry point. The downward half is laid out at falling addresses starting one byte below it. Each stream has its own byte-wide read port. A parser on each stream walks the bundle header one byte per cycle, then captures a fixed number of opcode slot fields and reads an optional delay item. When both halves are ready they issue together as one instruction: per-slot opcode bytes, each with a valid flag.

Slot fields are read speculatively, before it is known whether they fall inside the bundle's opcode region. A field that lies beyond the region's end, or beyond the bundle length, is masked off at issue. A bundle can give up an alignment-hole byte to hold a delay item for the opposite stream. That stream then issues a given number of empty instructions while its counter holds, so no explicit no-op bundles are needed. A restart input reloads both counters, drops any half-parsed bundles and clears pending delays. Free-running counters record stall cycles and the empty issues of each stream.

Top module: `bsq_dual_sequencer`

## Requirements
- R1: The cycle after `go` is sampled high, the upward stream reads `go_addr` and the downward stream reads `go_addr-1`. Any partly parsed bundle and any pending delay are discarded, and `issue_valid` is low in that cycle. While `go` is high, `issue_valid` is low.
- R2: Bundle byte 0 gives the total length in bytes. Byte 1 gives the end offset of the opcode region, which starts at byte 3. Byte 2 gives the end offset of the hole region, which starts at the opcode end. Bytes from the hole end up to the length are skipped.
- R3: Byte k of an upward bundle is at pc+k and byte k of a downward bundle is at pc-1-k. After the stream issues its bundle, the upward pc grows by the length and the downward pc shrinks by the length.
- R4: Slot i carries bundle byte 3+i. It is valid only when 3+i is below both the opcode end offset and the length. Fields that are fetched but lie outside these bounds are never flagged valid.
- R5: `issue_valid` is high only when each stream either holds a parsed bundle or owes delay cycles. Each stream that is not delaying consumes its bundle at that issue.
- R6: The byte at the opcode end offset is a delay item when the hole region is non-empty and that offset is below the length. With bit 7 set, bits 6:0 add that many delay cycles to the opposite stream. With bit 7 clear, the byte has no effect. Delays that arrive while a stream is already delaying add to its remaining count.
- R7: At an issue where a stream owes delay cycles, that stream shows no valid slot, keeps its counter, and its remaining count drops by one.
- R8: With NSLOT slots, a stream reaches the ready state 3+NSLOT cycles after starting a bundle, or one cycle later when it reads a delay item. With 8 slots and no delay items, the first issue is visible 11 clock edges after the edge that samples `go`.
- R9: `stall_cnt` counts cycles after the first `go` in which no issue occurs. `up_nop_cnt` and `dn_nop_cnt` count issues in which the respective stream was delaying.
- R10: After reset, no issue occurs, all counters read zero and both streams stay idle until `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Restart both streams at `go_addr` |
| go_addr | input | ADDR_W | Shared entry address |
| up_rd_addr | output | ADDR_W | Upward stream byte address |
| up_rd_data | input | 8 | Upward stream byte read data, same cycle |
| dn_rd_addr | output | ADDR_W | Downward stream byte address |
| dn_rd_data | input | 8 | Downward stream byte read data, same cycle |
| issue_valid | output | 1 | An instruction issues this cycle |
| up_slots | output | NSLOT*8 | Upward slot fields, slot i at bits 8i+7:8i |
| up_slot_vld | output | NSLOT | Upward per-slot valid flags |
| dn_slots | output | NSLOT*8 | Downward slot fields |
| dn_slot_vld | output | NSLOT | Downward per-slot valid flags |
| stall_cnt | output | CNT_W | Cycles without issue since the first restart |
| up_nop_cnt | output | CNT_W | Delay issues of the upward stream |
| dn_nop_cnt | output | CNT_W | Delay issues of the downward stream |

## Verification
The bench builds the block with an 8-bit address and the full 8 slots, so a 256-byte array can hold the whole memory image. Both programs then fit on either side of one entry point, and a second small program fits beside them. The main program sweeps the opcode count from zero to eight in one stream and from eight to zero in the other. This exercises every valid-mask width, a truncated length, delay items with bit 7 set and clear, and delays that overlap. The second program and a restart issued mid-bundle bring the one-cycle cost of a delay item and the flush on restart within reach.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   localparam int HDR_BYTES = 3;
   localparam int DLY_FLAG  = 7;
   localparam int DLY_VAL_W = 7;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_HDR0,
      PS_HDR1,
      PS_HDR2,
      PS_FIELD,
      PS_HOLE,
      PS_READY
   } parse_st_t;
endpackage

// File: rtl/bsq_stream_parser.sv
module bsq_stream_parser
   import bsq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NSLOT  = 8,
   parameter bit DOWN   = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [ADDR_W-1:0]     go_addr,
   input  logic                  take,
   output logic [ADDR_W-1:0]     rd_addr,
   input  logic [7:0]            rd_data,
   output logic                  ready,
   output logic [NSLOT*8-1:0]    fields,
   output logic [NSLOT-1:0]      vld_mask,
   output logic [DLY_VAL_W-1:0]  hole_dly
);
   localparam int FC_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam logic [FC_W-1:0] FC_LAST = FC_W'(NSLOT - 1);

   if (NSLOT < 1 || NSLOT > 8) begin : g_bad_nslot
      $error("bsq_stream_parser: NSLOT must be 1..8");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("bsq_stream_parser: ADDR_W must be at least 8");
   end

   parse_st_t                  state_q;
   logic [ADDR_W-1:0]          pc_q;
   logic [ADDR_W-1:0]          pc_next;
   logic [7:0]                 idx_q;
   logic [7:0]                 len_q;
   logic [7:0]                 op_end_q;
   logic [7:0]                 hole_end_q;
   logic [FC_W-1:0]            fcnt_q;
   logic [NSLOT-1:0][7:0]      fld_q;
   logic [DLY_VAL_W-1:0]       hole_q;
   logic                       hole_present;

   if (DOWN) begin : g_down
      assign rd_addr = pc_q - ADDR_W'(1) - ADDR_W'(idx_q);
      assign pc_next = pc_q - ADDR_W'(len_q);
   end else begin : g_up
      assign rd_addr = pc_q + ADDR_W'(idx_q);
      assign pc_next = pc_q + ADDR_W'(len_q);
   end

   assign hole_present = (op_end_q < hole_end_q) && (op_end_q < len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= PS_IDLE;
         pc_q       <= '0;
         idx_q      <= '0;
         len_q      <= '0;
         op_end_q   <= '0;
         hole_end_q <= '0;
         fcnt_q     <= '0;
         fld_q      <= '0;
         hole_q     <= '0;
      end else if (go) begin
         state_q <= PS_HDR0;
         pc_q    <= go_addr;
         idx_q   <= '0;
         hole_q  <= '0;
      end else begin
         unique case (state_q)
            PS_HDR0: begin
               len_q   <= rd_data;
               hole_q  <= '0;
               idx_q   <= 8'd1;
               state_q <= PS_HDR1;
            end
            PS_HDR1: begin
               op_end_q <= rd_data;
               idx_q    <= 8'd2;
               state_q  <= PS_HDR2;
            end
            PS_HDR2: begin
               hole_end_q <= rd_data;
               idx_q      <= 8'(HDR_BYTES);
               fcnt_q     <= '0;
               state_q    <= PS_FIELD;
            end
            PS_FIELD: begin
               fld_q[fcnt_q] <= rd_data;
               fcnt_q        <= fcnt_q + FC_W'(1);
               idx_q         <= idx_q + 8'd1;
               if (fcnt_q == FC_LAST) begin
                  if (hole_present) begin
                     idx_q   <= op_end_q;
                     state_q <= PS_HOLE;
                  end else begin
                     state_q <= PS_READY;
                  end
               end
            end
            PS_HOLE: begin
               hole_q  <= rd_data[DLY_FLAG] ? rd_data[DLY_VAL_W-1:0] : '0;
               state_q <= PS_READY;
            end
            PS_READY: begin
               if (take) begin
                  pc_q    <= pc_next;
                  idx_q   <= '0;
                  state_q <= PS_HDR0;
               end
            end
            default: ;
         endcase
      end
   end

   assign ready    = (state_q == PS_READY);
   assign fields   = fld_q;
   assign hole_dly = hole_q;

   for (genvar i = 0; i < NSLOT; i++) begin : g_mask
      localparam logic [8:0] POS = 9'(HDR_BYTES + i);
      assign vld_mask[i] = (POS < {1'b0, op_end_q}) && (POS < {1'b0, len_q});
   end

   // R1: restart reloads the counter from the entry address
   assert_go_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (rd_addr == (DOWN ? $past(go_addr) - ADDR_W'(1) : $past(go_addr))));

   // R4: speculative field fetch walks one byte per cycle in the stream direction
   assert_field_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_FIELD && $past(state_q) == PS_FIELD && !$past(go))
      |-> (rd_addr == (DOWN ? $past(rd_addr) - ADDR_W'(1) : $past(rd_addr) + ADDR_W'(1))));

   // R3: a parsed bundle waits with its counter frozen until consumed
   assert_ready_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !take && !go) |=> (ready && $stable(rd_addr)));
endmodule

// File: rtl/bsq_delay_ctr.sv
module bsq_delay_ctr
   import bsq_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic                 issue,
   input  logic                 load_en,
   input  logic [DLY_VAL_W-1:0] load_val,
   output logic                 busy
);
   localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};

   if (DLY_W < DLY_VAL_W) begin : g_bad_dw
      $error("bsq_delay_ctr: DLY_W must hold a delay item");
   end

   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] base;
   logic [DLY_W:0]   sum;
   logic [DLY_W-1:0] cnt_d;

   assign busy = (cnt_q != '0);

   always_comb begin
      base  = (issue && busy) ? cnt_q - DLY_W'(1) : cnt_q;
      sum   = {1'b0, base} + (load_en ? (DLY_W+1)'(load_val) : '0);
      cnt_d = sum[DLY_W] ? DLY_MAX : sum[DLY_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (go)  cnt_q <= '0;
      else          cnt_q <= cnt_d;
   end

   // R7: each delaying issue retires exactly one owed cycle
   assert_delay_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && issue && !load_en && !go) |=> (cnt_q == $past(cnt_q) - DLY_W'(1)));

   // R1: a restart clears any owed delay
   assert_delay_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !busy);
endmodule

// File: rtl/bsq_stat_cnt.sv
module bsq_stat_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             issue,
   input  logic             up_dly,
   input  logic             dn_dly,
   output logic [CNT_W-1:0] stall_cnt,
   output logic [CNT_W-1:0] up_nop_cnt,
   output logic [CNT_W-1:0] dn_nop_cnt
);
   if (CNT_W < 2) begin : g_bad_cw
      $error("bsq_stat_cnt: CNT_W too small");
   end

   logic started_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q  <= 1'b0;
         stall_cnt  <= '0;
         up_nop_cnt <= '0;
         dn_nop_cnt <= '0;
      end else begin
         if (go)                     started_q  <= 1'b1;
         if (started_q && !issue)    stall_cnt  <= stall_cnt + CNT_W'(1);
         if (issue && up_dly)        up_nop_cnt <= up_nop_cnt + CNT_W'(1);
         if (issue && dn_dly)        dn_nop_cnt <= dn_nop_cnt + CNT_W'(1);
      end
   end

   // R9: the no-op counters move by at most one per cycle
   assert_nop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((up_nop_cnt - $past(up_nop_cnt)) <= CNT_W'(1)
             && (dn_nop_cnt - $past(dn_nop_cnt)) <= CNT_W'(1)));

   // R10: nothing counts before the first restart
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !started_q |-> (stall_cnt == '0));
endmodule

// File: rtl/bsq_dual_sequencer.sv
module bsq_dual_sequencer
   import bsq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NSLOT  = 8,
   parameter int DLY_W  = 8,
   parameter int CNT_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic [ADDR_W-1:0]   go_addr,
   output logic [ADDR_W-1:0]   up_rd_addr,
   input  logic [7:0]          up_rd_data,
   output logic [ADDR_W-1:0]   dn_rd_addr,
   input  logic [7:0]          dn_rd_data,
   output logic                issue_valid,
   output logic [NSLOT*8-1:0]  up_slots,
   output logic [NSLOT-1:0]    up_slot_vld,
   output logic [NSLOT*8-1:0]  dn_slots,
   output logic [NSLOT-1:0]    dn_slot_vld,
   output logic [CNT_W-1:0]    stall_cnt,
   output logic [CNT_W-1:0]    up_nop_cnt,
   output logic [CNT_W-1:0]    dn_nop_cnt
);
   localparam int NSTREAM = 2;

   logic [NSTREAM-1:0]                 ready_s;
   logic [NSTREAM-1:0]                 busy_s;
   logic [NSTREAM-1:0]                 take_s;
   logic [NSTREAM-1:0][DLY_VAL_W-1:0]  hole_s;
   logic [NSTREAM-1:0][NSLOT-1:0]      mask_s;
   logic [NSTREAM-1:0][NSLOT*8-1:0]    fld_s;
   logic [NSTREAM-1:0][ADDR_W-1:0]     addr_s;
   logic [NSTREAM-1:0][7:0]            data_s;
   logic                               issue;

   assign data_s[0] = up_rd_data;
   assign data_s[1] = dn_rd_data;

   assign issue  = !go && (&(ready_s | busy_s));
   assign take_s = {NSTREAM{issue}} & ~busy_s;

   for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
      bsq_stream_parser #(
         .ADDR_W (ADDR_W),
         .NSLOT  (NSLOT),
         .DOWN   (s == 1)
      ) u_parse (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (go),
         .go_addr  (go_addr),
         .take     (take_s[s]),
         .rd_addr  (addr_s[s]),
         .rd_data  (data_s[s]),
         .ready    (ready_s[s]),
         .fields   (fld_s[s]),
         .vld_mask (mask_s[s]),
         .hole_dly (hole_s[s])
      );

      bsq_delay_ctr #(
         .DLY_W (DLY_W)
      ) u_dly (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (go),
         .issue    (issue),
         .load_en  (take_s[NSTREAM-1-s]),
         .load_val (hole_s[NSTREAM-1-s]),
         .busy     (busy_s[s])
      );
   end

   bsq_stat_cnt #(
      .CNT_W (CNT_W)
   ) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .issue      (issue),
      .up_dly     (busy_s[0]),
      .dn_dly     (busy_s[1]),
      .stall_cnt  (stall_cnt),
      .up_nop_cnt (up_nop_cnt),
      .dn_nop_cnt (dn_nop_cnt)
   );

   assign up_rd_addr  = addr_s[0];
   assign dn_rd_addr  = addr_s[1];
   assign issue_valid = issue;
   assign up_slots    = fld_s[0];
   assign dn_slots    = fld_s[1];
   assign up_slot_vld = take_s[0] ? mask_s[0] : '0;
   assign dn_slot_vld = take_s[1] ? mask_s[1] : '0;

   // R1: no instruction can issue in the cycle right after a restart
   assert_no_issue_after_go_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(go) |-> !issue_valid);

   // R5: a valid slot appears only on an issue cycle
   assert_slots_need_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((up_slot_vld != '0) || (dn_slot_vld != '0)) |-> issue_valid);

   // R7: a stream that spends an issue delaying keeps its parsed bundle and counter
   assert_delay_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && busy_s[0] && ready_s[0]) |=> (ready_s[0] && $stable(up_rd_addr)));
endmodule

// File: tb/sim_bsq_dual_sequencer.sv
module sim_bsq_dual_sequencer;
   localparam int AW = 8;
   localparam int NS = 8;
   localparam int CW = 16;
   localparam int NB = 9;
   localparam int E  = 8'h80;
   localparam int E2 = 8'h20;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n, go;
   logic [AW-1:0]     go_addr, up_rd_addr, dn_rd_addr;
   logic [7:0]        up_rd_data, dn_rd_data;
   logic              issue_valid;
   logic [NS*8-1:0]   up_slots, dn_slots;
   logic [NS-1:0]     up_slot_vld, dn_slot_vld;
   logic [CW-1:0]     stall_cnt, up_nop_cnt, dn_nop_cnt;

   logic [7:0] mem [256];
   assign up_rd_data = mem[up_rd_addr];
   assign dn_rd_data = mem[dn_rd_addr];

   bsq_dual_sequencer #(.ADDR_W(AW), .NSLOT(NS), .DLY_W(8), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr),
      .up_rd_addr(up_rd_addr), .up_rd_data(up_rd_data),
      .dn_rd_addr(dn_rd_addr), .dn_rd_data(dn_rd_data),
      .issue_valid(issue_valid),
      .up_slots(up_slots), .up_slot_vld(up_slot_vld),
      .dn_slots(dn_slots), .dn_slot_vld(dn_slot_vld),
      .stall_cnt(stall_cnt), .up_nop_cnt(up_nop_cnt), .dn_nop_cnt(dn_nop_cnt));

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   int u_nf[NB], u_hole[NB], u_pad[NB];
   int d_nf[NB], d_hole[NB], d_pad[NB];
   bit u_tr[NB], d_tr[NB];

   task automatic chk(input bit ok, input string req, input string what);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s", req, what);
      end
   endtask

   function automatic int baddr(input int s, input int pc, input int k);
      return (s == 0) ? ((pc + k) & 255) : ((pc - 1 - k) & 255);
   endfunction

   function automatic int dly(input int b);
      return (b & 8'h80) ? (b & 8'h7f) : 0;
   endfunction

   // lay out one bundle following the R2 format, advancing pc per R3
   task automatic put_bundle(input int s, input int b, input int nf, input int hole,
                             input int pad, input bit tr, inout int pc);
      int len, op_end, hole_end;
      op_end   = 3 + nf;
      hole_end = op_end + ((hole != 0) ? 1 : 0);
      len      = hole_end + pad;
      if (tr) begin
         len      = 3 + nf;
         op_end   = 3 + nf + 4;
         hole_end = op_end;
      end
      mem[baddr(s, pc, 0)] = 8'(len);
      mem[baddr(s, pc, 1)] = 8'(op_end);
      mem[baddr(s, pc, 2)] = 8'(hole_end);
      for (int i = 0; i < nf; i++) mem[baddr(s, pc, 3 + i)] = 8'(s * 128 + b * 8 + i);
      if (hole != 0 && !tr) mem[baddr(s, pc, 3 + nf)] = 8'(hole);
      for (int p = 0; p < pad; p++) mem[baddr(s, pc, hole_end + p)] = 8'hEE;
      pc = (s == 0) ? (pc + len) : (pc - len);
   endtask

   function automatic bit slots_match(input logic [NS*8-1:0] f, input logic [NS-1:0] m,
                                      input int s, input int b, input int nf);
      bit ok = (m == NS'((1 << nf) - 1));
      for (int i = 0; i < NS; i++)
         if (m[i] && f[i*8 +: 8] != 8'(s * 128 + b * 8 + i)) ok = 1'b0;
      return ok;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      int pc, edges, ui, di, ud, dd, nu, nd, exp_stall, exp_unop, exp_dnop, nop0;
      bit ut, dt, ok;
      rst_n = 1'b0; go = 1'b0; go_addr = '0;
      for (int a = 0; a < 256; a++) mem[a] = 8'h00;
      for (int b = 0; b < NB; b++) begin
         u_nf[b] = b;      u_pad[b] = b % 3;       u_hole[b] = 0; u_tr[b] = (b == 6);
         d_nf[b] = 8 - b;  d_pad[b] = (b + 1) % 2; d_hole[b] = 0; d_tr[b] = 1'b0;
      end
      u_hole[2] = 8'h83; u_hole[5] = 8'h05; u_hole[7] = 8'h81;
      d_hole[1] = 8'h81; d_hole[4] = 8'h82; d_hole[7] = 8'h81;
      pc = E; for (int b = 0; b < NB; b++) put_bundle(0, b, u_nf[b], u_hole[b], u_pad[b], u_tr[b], pc);
      pc = E; for (int b = 0; b < NB; b++) put_bundle(1, b, d_nf[b], d_hole[b], d_pad[b], d_tr[b], pc);
      pc = E2; put_bundle(0, 10, 2, 8'h82, 0, 1'b0, pc);
      pc = E2; put_bundle(1, 10, 1, 0, 0, 1'b0, pc);

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!issue_valid && up_slot_vld == 0 && dn_slot_vld == 0, "R10",
          $sformatf("issue=%0d expected 0 after reset", issue_valid));
      chk(stall_cnt == 0 && up_nop_cnt == 0 && dn_nop_cnt == 0, "R10",
          $sformatf("counters %0d/%0d/%0d expected 0/0/0", stall_cnt, up_nop_cnt, dn_nop_cnt));
      ok = 1'b1;
      repeat (4) begin @(negedge clk); if (issue_valid || stall_cnt != 0) ok = 1'b0; end
      chk(ok, "R10", "issue or stall count seen before any restart, expected none");

      // main program: sweep of opcode counts with delay items
      @(posedge clk); #1 go = 1'b1; go_addr = AW'(E);
      @(posedge clk); #1 go = 1'b0;
      @(negedge clk);
      chk(up_rd_addr == AW'(E) && dn_rd_addr == AW'(E - 1), "R1",
          $sformatf("addr up=%0h dn=%0h expected %0h/%0h", up_rd_addr, dn_rd_addr, E, E - 1));
      exp_stall = 0; edges = 0;
      while (!issue_valid && edges < 40) begin
         exp_stall++; @(posedge clk); edges++; @(negedge clk);
      end
      chk(edges == 11, "R8", $sformatf("first issue after %0d edges, expected 11", edges));

      ui = 0; di = 0; ud = 0; dd = 0; exp_unop = 0; exp_dnop = 0;
      for (int cyc = 0; cyc < 2000; cyc++) begin
         if (issue_valid) begin
            ut = (ud == 0); dt = (dd == 0);
            if (ut) chk(slots_match(up_slots, up_slot_vld, 0, ui, u_nf[ui]), "R4",
                        $sformatf("up bundle %0d mask=%0h expected %0h", ui, up_slot_vld, (1 << u_nf[ui]) - 1));
            else    chk(up_slot_vld == 0, "R7",
                        $sformatf("up delaying mask=%0h expected 0", up_slot_vld));
            if (dt) chk(slots_match(dn_slots, dn_slot_vld, 1, di, d_nf[di]), "R3",
                        $sformatf("dn bundle %0d mask=%0h expected %0h", di, dn_slot_vld, (1 << d_nf[di]) - 1));
            else    chk(dn_slot_vld == 0, "R7",
                        $sformatf("dn delaying mask=%0h expected 0", dn_slot_vld));
            nu = ut ? 0 : ud - 1; nd = dt ? 0 : dd - 1;
            if (ut) nd += dly(u_hole[ui]);   // R6
            if (dt) nu += dly(d_hole[di]);
            if (!ut) exp_unop++;
            if (!dt) exp_dnop++;
            ui += int'(ut); di += int'(dt); ud = nu; dd = nd;
         end else begin
            exp_stall++;
         end
         if (ui == NB || di == NB) break;
         @(posedge clk); @(negedge clk);
      end
      chk(ui == NB || di == NB, "R5", $sformatf("issued %0d/%0d bundles, expected %0d", ui, di, NB));
      @(posedge clk); @(negedge clk);
      chk(stall_cnt == CW'(exp_stall), "R9", $sformatf("stall_cnt=%0d expected %0d", stall_cnt, exp_stall));
      chk(up_nop_cnt == CW'(exp_unop) && dn_nop_cnt == CW'(exp_dnop), "R6",
          $sformatf("nop counts %0d/%0d expected %0d/%0d", up_nop_cnt, dn_nop_cnt, exp_unop, exp_dnop));

      // restart in the middle of a bundle, then restart again at the main entry
      @(posedge clk); #1 go = 1'b1; go_addr = AW'(E2);
      @(posedge clk); #1 go = 1'b0;
      repeat (4) @(posedge clk);
      #1 go = 1'b1; go_addr = AW'(E);
      @(negedge clk);
      chk(!issue_valid, "R1", "issue seen while restart held, expected none");
      @(posedge clk); #1 go = 1'b0;
      @(negedge clk);
      chk(up_rd_addr == AW'(E) && dn_rd_addr == AW'(E - 1) && !issue_valid, "R1",
          $sformatf("re-entry addr up=%0h dn=%0h expected %0h/%0h", up_rd_addr, dn_rd_addr, E, E - 1));
      edges = 0;
      while (!issue_valid && edges < 40) begin @(posedge clk); edges++; @(negedge clk); end
      chk(edges == 11, "R8", $sformatf("re-entry issue after %0d edges, expected 11", edges));
      chk(slots_match(up_slots, up_slot_vld, 0, 0, 0) && slots_match(dn_slots, dn_slot_vld, 1, 0, 8), "R1",
          $sformatf("re-entry masks %0h/%0h expected 0/ff", up_slot_vld, dn_slot_vld));

      // second program: upward bundle carries a delay item of 2 for the downward stream
      @(posedge clk); #1 go = 1'b1; go_addr = AW'(E2);
      @(posedge clk); #1 go = 1'b0;
      @(negedge clk); edges = 0;
      while (!issue_valid && edges < 40) begin @(posedge clk); edges++; @(negedge clk); end
      chk(edges == 12, "R8", $sformatf("issue with delay item after %0d edges, expected 12", edges));
      chk(slots_match(up_slots, up_slot_vld, 0, 10, 2) && slots_match(dn_slots, dn_slot_vld, 1, 10, 1), "R2",
          $sformatf("masks %0h/%0h expected 3/1", up_slot_vld, dn_slot_vld));
      nop0 = int'(dn_nop_cnt);
      ok = 1'b1;
      for (int k = 0; k < 2; k++) begin
         @(posedge clk); @(negedge clk); edges = 0;
         while (!issue_valid && edges < 40) begin @(posedge clk); edges++; @(negedge clk); end
         if (!issue_valid || dn_slot_vld != 0) ok = 1'b0;
      end
      chk(ok, "R7", $sformatf("dn mask=%0h during owed delay, expected 0", dn_slot_vld));
      @(posedge clk); @(negedge clk);
      chk(int'(dn_nop_cnt) == nop0 + 2, "R9",
          $sformatf("dn_nop_cnt=%0d expected %0d", dn_nop_cnt, nop0 + 2));

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule